// File: doc/BRIEF.md
# ADC Pause-Mode Channel Sequencer

This block steps a multi-channel analog-to-digital converter through a window of channels, one channel per trigger. Each accepted trigger issues a single-cycle conversion-start strobe together with a channel number. The block then waits for the converter core's done strobe. After that it parks in a paused state until the next trigger. Once the end channel has converted, the following trigger starts again at the start channel. The channel count runs modulo 16, so a start above the end wraps through 15 to 0.

The trigger that counts comes from a 2-bit source select. Source 0 is a software start pulse. Sources 1 to 3 are rising edges on asynchronous trigger pins, which are synchronised inside the block. A forced-stop strobe clears the busy flag, drops any running conversion and returns the block to idle. The next trigger after a stop therefore begins again at the start channel. Triggers that land while a conversion is running are discarded.

Top module: `adc_pause_seq`

## Requirements
- R1: After reset, `busy`, `conv_start`, `conv_ch` and `done_ch` are all 0.
- R2: From idle, a `sw_start` pulse sampled at a clock edge (with source select 0) gives `conv_start`=1 and `conv_ch`=`cfg_start_ch` right after that edge, and sets `busy` to 1.
- R3: `conv_done` high at an edge while converting moves the block to paused and loads `done_ch` with the channel just converted, visible right after that edge.
- R4: A trigger accepted while paused starts a conversion on the previous channel plus one, modulo 16.
- R5: A trigger accepted while paused after the end channel (`cfg_end_ch`) has converted starts the start channel again. When start equals end, every trigger converts that one channel.
- R6: When `cfg_start_ch` is greater than `cfg_end_ch`, the sequence counts up through 15 and continues at 0 before reaching the end channel.
- R7: Triggers that arrive while a conversion is in progress produce no `conv_start` and do not change `conv_ch`.
- R8: A `busy_clr` pulse forces `busy` to 0 and the block to idle on the next edge. It takes priority over a simultaneous trigger. The next trigger afterwards converts the start channel.
- R9: Source select k in 1..3 accepts only a rising edge of `ext_trig[k-1]`, after two synchronising flops (conversion starts three edges after the pin rises). A held high level does not retrigger. Unselected sources are ignored.
- R10: `busy` stays 1 through conversions and pauses until a forced stop.
- R11: `conv_start` is high for exactly one clock per accepted trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start_ch | input | 4 | First channel of the window |
| cfg_end_ch | input | 4 | Last channel of the window |
| cfg_trig_sel | input | 2 | Trigger source: 0 software, 1..3 external pins |
| sw_start | input | 1 | Software start pulse |
| ext_trig | input | 3 | Asynchronous external/timer trigger pins |
| busy_clr | input | 1 | Forced stop (write of 0 to the busy flag) |
| conv_done | input | 1 | Converter finished the current channel |
| conv_start | output | 1 | Single-cycle conversion start strobe |
| conv_ch | output | 4 | Channel being converted |
| busy | output | 1 | Sequencer active flag |
| done_ch | output | 4 | Channel number of the last completed conversion |

## Verification
The bench uses the default build: 4-bit channel selects, a 2-bit source select with three external pins, and two synchronising stages. This covers all sixteen channels. It also covers the wrap from 15 to 0, equal start and end selects, and every trigger source together with its fixed three-edge latency. Random windows and trigger counts run against a bench model of the next channel. Directed cases cover discarded triggers during conversion, a stop that collides with a trigger, and a held trigger level.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_CONV  = 2'd1,
    SEQ_PAUSE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adcseq_trig_sel.sv
module adcseq_trig_sel #(
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int SRC_N      = 2 ** SEL_W,
  localparam int EXT_N      = SRC_N - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             sw_start,
  input  logic [EXT_N-1:0] ext_trig,
  output logic             trig_hit
);
  logic [SRC_N-1:0] src;

  assign src[0] = sw_start;

  for (genvar g = 0; g < EXT_N; g++) begin : g_ext
    // SYNC_STAGES synchroniser flops plus one history flop for edge detect
    logic [SYNC_STAGES:0] shreg;
    always_ff @(posedge clk) begin
      if (rst) shreg <= '0;
      else     shreg <= {shreg[SYNC_STAGES-1:0], ext_trig[g]};
    end
    assign src[g+1] = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];

    // an edge pulse never lasts two cycles, so a held level cannot retrigger
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      src[g+1] |=> !src[g+1]); // R9
  end

  assign trig_hit = src[sel];
endmodule

// File: rtl/adcseq_chan_next.sv
module adcseq_chan_next #(
  parameter int CH_W = 4
) (
  input  logic            from_idle,
  input  logic [CH_W-1:0] start_ch,
  input  logic [CH_W-1:0] end_ch,
  input  logic [CH_W-1:0] last_ch,
  output logic [CH_W-1:0] next_ch
);
  always_comb begin
    if (from_idle || last_ch == end_ch) next_ch = start_ch;
    else                                next_ch = last_ch + 1'b1; // modulo 2**CH_W
  end

  always_comb begin
    AST_NEXT_IN_WINDOW: assert (next_ch == start_ch || next_ch == last_ch + 1'b1); // R4
  end
endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
  import adcseq_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trig_hit,
  input  logic            busy_clr,
  input  logic            conv_done,
  input  logic [CH_W-1:0] next_ch,
  input  logic [CH_W-1:0] start_ch,
  input  logic [CH_W-1:0] end_ch,
  output logic            in_idle,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_ch,
  output logic            busy,
  output logic [CH_W-1:0] done_ch
);
  seq_state_t state;
  logic       accept;

  assign accept  = trig_hit && (state != SEQ_CONV) && !busy_clr;
  assign in_idle = (state == SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      conv_start <= 1'b0;
      conv_ch    <= '0;
      busy       <= 1'b0;
      done_ch    <= '0;
    end else begin
      conv_start <= 1'b0;
      if (busy_clr) begin
        state <= SEQ_IDLE;
        busy  <= 1'b0;
      end else if (accept) begin
        state      <= SEQ_CONV;
        conv_start <= 1'b1;
        conv_ch    <= next_ch;
        busy       <= 1'b1;
      end else if (state == SEQ_CONV && conv_done) begin
        state   <= SEQ_PAUSE;
        done_ch <= conv_ch;
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start); // R11
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_CONV && !conv_done && !busy_clr) |=> (!conv_start && $stable(conv_ch))); // R7
  AST_STOP: assert property (@(posedge clk) disable iff (rst)
    busy_clr |=> (!busy && !conv_start)); // R8
  AST_DONE_LATCH: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_CONV && conv_done && !busy_clr) |=> (done_ch == $past(conv_ch))); // R3
  AST_WRAP_START: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_PAUSE && accept && conv_ch == end_ch) |=> (conv_ch == $past(start_ch))); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !busy_clr) |=> busy); // R10
endmodule

// File: rtl/adc_pause_seq.sv
module adc_pause_seq #(
  parameter int CH_W        = 4,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int EXT_N      = 2 ** SEL_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH_W-1:0]  cfg_start_ch,
  input  logic [CH_W-1:0]  cfg_end_ch,
  input  logic [SEL_W-1:0] cfg_trig_sel,
  input  logic             sw_start,
  input  logic [EXT_N-1:0] ext_trig,
  input  logic             busy_clr,
  input  logic             conv_done,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_ch,
  output logic             busy,
  output logic [CH_W-1:0]  done_ch
);
  logic            trig_hit;
  logic            in_idle;
  logic [CH_W-1:0] next_ch;

  adcseq_trig_sel #(.SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) trig_i (
    .clk      (clk),
    .rst      (rst),
    .sel      (cfg_trig_sel),
    .sw_start (sw_start),
    .ext_trig (ext_trig),
    .trig_hit (trig_hit)
  );

  adcseq_chan_next #(.CH_W(CH_W)) next_i (
    .from_idle (in_idle),
    .start_ch  (cfg_start_ch),
    .end_ch    (cfg_end_ch),
    .last_ch   (conv_ch),
    .next_ch   (next_ch)
  );

  adcseq_fsm #(.CH_W(CH_W)) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .trig_hit   (trig_hit),
    .busy_clr   (busy_clr),
    .conv_done  (conv_done),
    .next_ch    (next_ch),
    .start_ch   (cfg_start_ch),
    .end_ch     (cfg_end_ch),
    .in_idle    (in_idle),
    .conv_start (conv_start),
    .conv_ch    (conv_ch),
    .busy       (busy),
    .done_ch    (done_ch)
  );
endmodule

// File: tb/adc_pause_seq_tb.sv
module adc_pause_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cfg_start_ch = '0;
  logic [3:0] cfg_end_ch = '0;
  logic [1:0] cfg_trig_sel = '0;
  logic       sw_start = 1'b0;
  logic [2:0] ext_trig = '0;
  logic       busy_clr = 1'b0;
  logic       conv_done = 1'b0;
  logic       conv_start;
  logic [3:0] conv_ch;
  logic       busy;
  logic [3:0] done_ch;

  int checks = 0;
  int fails = 0;
  int starts = 0;
  int cycles = 0;
  logic [3:0] last_ch = '0;
  logic       first = 1'b1;

  always #4 clk = ~clk;

  adc_pause_seq dut_i (
    .clk(clk), .rst(rst), .cfg_start_ch(cfg_start_ch), .cfg_end_ch(cfg_end_ch),
    .cfg_trig_sel(cfg_trig_sel), .sw_start(sw_start), .ext_trig(ext_trig),
    .busy_clr(busy_clr), .conv_done(conv_done), .conv_start(conv_start),
    .conv_ch(conv_ch), .busy(busy), .done_ch(done_ch)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (conv_start) starts <= starts + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model_next(input logic [3:0] last, input logic [3:0] s,
                                            input logic [3:0] e, input logic fst);
    if (fst || last == e) return s;
    return last + 4'd1;
  endfunction

  // software trigger; conv_start must be visible at the following negedge
  task automatic sw_trig(input string req);
    logic [3:0] exp;
    exp = model_next(last_ch, cfg_start_ch, cfg_end_ch, first);
    @(negedge clk) sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
    chk(conv_start === 1'b1, req, conv_start, 1);
    chk(conv_ch === exp, req, conv_ch, exp);
    chk(busy === 1'b1, "R2", busy, 1);
    @(negedge clk);
    chk(conv_start === 1'b0, "R11", conv_start, 0);
    last_ch = exp;
    first = 1'b0;
  endtask

  task automatic finish_conv();
    @(negedge clk) conv_done = 1'b1;
    @(negedge clk) conv_done = 1'b0;
    chk(done_ch === last_ch, "R3", done_ch, last_ch);
    chk(busy === 1'b1, "R10", busy, 1);
  endtask

  task automatic stop();
    @(negedge clk) busy_clr = 1'b1;
    @(negedge clk) busy_clr = 1'b0;
    chk(busy === 1'b0, "R8", busy, 0);
    first = 1'b1;
  endtask

  initial begin
    int base;
    int dly;
    logic [3:0] exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 0 && conv_start === 0, "R1", busy, 0);
    chk(conv_ch === 0 && done_ch === 0, "R1", conv_ch, 0);

    // R4 R5: window 0..3 twice round
    cfg_start_ch = 4'd0; cfg_end_ch = 4'd3;
    for (int i = 0; i < 8; i++) begin
      sw_trig(i == 0 ? "R2" : (i == 4 ? "R5" : "R4"));
      finish_conv();
    end
    stop();

    // R5: equal start and end
    cfg_start_ch = 4'd3; cfg_end_ch = 4'd3;
    for (int i = 0; i < 3; i++) begin
      sw_trig("R5");
      chk(conv_ch === 4'd3, "R5", conv_ch, 3);
      finish_conv();
    end
    stop();

    // R6: start above end wraps 15 -> 0
    cfg_start_ch = 4'd14; cfg_end_ch = 4'd1;
    for (int i = 0; i < 5; i++) begin
      sw_trig("R6");
      finish_conv();
    end
    chk(conv_ch === 4'd14, "R6", conv_ch, 14);

    // R7: triggers during a conversion are dropped
    sw_trig("R4");
    base = starts;
    @(negedge clk) sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
    repeat (3) @(negedge clk);
    chk(starts == base, "R7", starts, base);
    chk(conv_ch === last_ch, "R7", conv_ch, last_ch);
    finish_conv();

    // R8: stop colliding with a trigger
    @(negedge clk) begin busy_clr = 1'b1; sw_start = 1'b1; end
    @(negedge clk) begin busy_clr = 1'b0; sw_start = 1'b0; end
    chk(busy === 1'b0 && conv_start === 1'b0, "R8", conv_start, 0);
    first = 1'b1;
    sw_trig("R8");
    chk(conv_ch === cfg_start_ch, "R8", conv_ch, cfg_start_ch);
    finish_conv();
    stop();

    // R9: external sources, latency 3 edges, held level, unselected pins
    cfg_start_ch = 4'd5; cfg_end_ch = 4'd9;
    for (int k = 1; k <= 3; k++) begin
      cfg_trig_sel = 2'(k);
      base = starts;
      @(negedge clk) ext_trig[k-1] = 1'b1;
      dly = 0;
      while (!conv_start && dly < 10) begin @(negedge clk); dly++; end
      chk(dly == 3, "R9", dly, 3);
      exp = model_next(last_ch, cfg_start_ch, cfg_end_ch, first);
      chk(conv_ch === exp, "R9", conv_ch, exp);
      last_ch = exp; first = 1'b0;
      finish_conv();
      repeat (6) @(negedge clk);
      chk(starts == base + 1, "R9", starts, base + 1);
      ext_trig[k-1] = 1'b0;
      // unselected pin and software start must do nothing
      base = starts;
      ext_trig[k % 3] = 1'b1;
      sw_start = 1'b1;
      @(negedge clk) sw_start = 1'b0;
      repeat (6) @(negedge clk);
      ext_trig[k % 3] = 1'b0;
      repeat (4) @(negedge clk);
      chk(starts == base, "R9", starts, base);
    end
    cfg_trig_sel = 2'd0;
    stop();

    // random windows against the model
    void'($urandom(32'd1234));
    for (int it = 0; it < 30; it++) begin
      cfg_start_ch = 4'($urandom_range(0, 15));
      cfg_end_ch   = 4'($urandom_range(0, 15));
      for (int n = 0; n < int'($urandom_range(1, 6)); n++) begin
        sw_trig("R4");
        if ($urandom_range(0, 3) == 0) begin
          base = starts;
          @(negedge clk) sw_start = 1'b1;
          @(negedge clk) sw_start = 1'b0;
          chk(starts == base, "R7", starts, base);
        end
        finish_conv();
      end
      stop();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule